// File: doc/BRIEF.md
# Five-Stage Exposed-Hazard Stream Core

A small in-order processor core that runs a fixed program from a 16-entry instruction store. Every clock it fetches the next instruction, reads operands, computes, carries the result through a spare stage and finally writes it into one of four 8-bit registers. The program counter only ever counts up and wraps, so the program replays every 16 cycles. There is no branch, memory or interrupt path.

The core makes no attempt to protect the program from itself. Nothing stalls, nothing forwards, and register writes land in the fifth stage. A result is therefore visible to a later instruction only when enough other instructions (usually nops) sit between producer and consumer. A consumer placed too close silently reads the stale value. The program store is filled through a write port while reset is held, and a debug port reads any register without disturbing the pipeline.

Top module: `stream5_core`

## Requirements
- R1: While rst_ni is low, all four registers read 0 on the debug port. After release, the program counter restarts at slot 0.
- R2: The instruction in store slot k (k from 0 to 15) writes its register at rising edge k+5 after reset release, and not earlier. Edges 1 to 4 retire bubbles.
- R3: Instruction word layout: opcode [11:9], destination [8:7], source A [6:5], source B [4:3], immediate [3:0]. Opcode 1 (move-immediate) writes the immediate zero-extended to 8 bits.
- R4: Opcode 2 (move) writes the value of source A into the destination.
- R5: Opcode 3 (add) writes source A plus source B modulo 256.
- R6: Opcode 4 (multiply) writes the low 8 bits of the 8x8 product of source A and source B.
- R7: Opcode 0 (nop) and the unused opcodes 5, 6 and 7 change no register, whatever their other fields hold.
- R8: There is no forwarding and no write-through. A consumer three slots after its producer reads the old value. A consumer four or more slots after it reads the new value.
- R9: The program counter advances by one every cycle and wraps from 15 to 0, so slot 0 runs again 16 edges after its first fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pgm_we_i | input | 1 | Program store write strobe |
| pgm_addr_i | input | 4 | Program store write slot |
| pgm_data_i | input | 12 | Instruction word to store |
| dbg_addr_i | input | 2 | Register selected for debug read |
| dbg_data_o | output | 8 | Value of the selected register |

## Verification
The bench builds the core with its defaults: 8-bit data and a 4-bit program counter. With 16 slots, the replay after the counter wraps comes within a few dozen cycles, so an accumulating add can show the second and third passes. With 8-bit data, products and sums of small immediates overflow, which reaches the truncation cases. Programs are built so that each producer–consumer distance of interest (adjacent, three slots, four slots) occurs inside the first pass.

// File: rtl/s5_pkg.sv
package s5_pkg;
  localparam int OP_W    = 3;
  localparam int RA_W    = 2;
  localparam int NREG    = 1 << RA_W;
  localparam int IMM_W   = 4;
  localparam int INSTR_W = 12;
  localparam int OP_LSB  = 9;
  localparam int RD_LSB  = 7;
  localparam int RSA_LSB = 5;
  localparam int RSB_LSB = 3;
  localparam int IMM_LSB = 0;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 3'd0,
    OP_MOVI = 3'd1,
    OP_MOV  = 3'd2,
    OP_ADD  = 3'd3,
    OP_MUL  = 3'd4
  } op_e;

  function automatic op_e decode_op(input logic [OP_W-1:0] code);
    case (code)
      3'd1:    return OP_MOVI;
      3'd2:    return OP_MOV;
      3'd3:    return OP_ADD;
      3'd4:    return OP_MUL;
      default: return OP_NOP;
    endcase
  endfunction
endpackage

// File: rtl/s5_fetch.sv
module s5_fetch #(
  parameter int PC_W    = 4,
  parameter int INSTR_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pgm_we_i,
  input  logic [PC_W-1:0]    pgm_addr_i,
  input  logic [INSTR_W-1:0] pgm_data_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [INSTR_W-1:0] instr_o
);
  localparam int DEPTH = 1 << PC_W;

  logic [INSTR_W-1:0] store_q [DEPTH];
  logic [PC_W-1:0]    pc_q;
  logic [INSTR_W-1:0] instr_q;

  always_ff @(posedge clk_i) begin
    if (pgm_we_i) store_q[pgm_addr_i] <= pgm_data_i;
  end

  // all-zero word is a nop, so the cleared latch is a bubble
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      instr_q <= '0;
    end else begin
      pc_q    <= pc_q + 1'b1;
      instr_q <= store_q[pc_q];
    end
  end

  assign pc_o    = pc_q;
  assign instr_o = instr_q;
endmodule

// File: rtl/s5_regfile.sv
module s5_regfile #(
  parameter int DATA_W = 8,
  parameter int RA_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [RA_W-1:0]   wa_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic [RA_W-1:0]   ra_a_i,
  input  logic [RA_W-1:0]   ra_b_i,
  input  logic [RA_W-1:0]   ra_dbg_i,
  output logic [DATA_W-1:0] rd_a_o,
  output logic [DATA_W-1:0] rd_b_o,
  output logic [DATA_W-1:0] rd_dbg_o
);
  localparam int NREG = 1 << RA_W;

  logic [DATA_W-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  // reads see the pre-edge contents: no write-through
  assign rd_a_o   = regs_q[ra_a_i];
  assign rd_b_o   = regs_q[ra_b_i];
  assign rd_dbg_o = regs_q[ra_dbg_i];
endmodule

// File: rtl/s5_alu.sv
module s5_alu #(
  parameter int DATA_W = 8
) (
  input  s5_pkg::op_e       op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              we_o
);
  import s5_pkg::*;

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_MUL:  res_o = a_i * b_i;
      default: res_o = a_i;   // movi carries its immediate on a
    endcase
    we_o = (op_i != OP_NOP);
  end
endmodule

// File: rtl/stream5_core.sv
module stream5_core #(
  parameter int DATA_W = 8,
  parameter int PC_W   = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       pgm_we_i,
  input  logic [PC_W-1:0]            pgm_addr_i,
  input  logic [s5_pkg::INSTR_W-1:0] pgm_data_i,
  input  logic [s5_pkg::RA_W-1:0]    dbg_addr_i,
  output logic [DATA_W-1:0]          dbg_data_o
);
  import s5_pkg::*;

  logic [PC_W-1:0]    pc;
  logic [INSTR_W-1:0] id_instr;

  // decode / read
  op_e               id_op;
  logic [RA_W-1:0]   id_rd, id_rsa, id_rsb;
  logic [IMM_W-1:0]  id_imm;
  logic [DATA_W-1:0] rf_a, rf_b, id_a;

  // execute
  op_e               ex_op;
  logic [RA_W-1:0]   ex_rd;
  logic [DATA_W-1:0] ex_a, ex_b, alu_res;
  logic              alu_we;

  // pass-through and writeback
  logic              mem_we, wb_we;
  logic [RA_W-1:0]   mem_rd, wb_rd;
  logic [DATA_W-1:0] mem_res, wb_data;

  s5_fetch #(.PC_W(PC_W), .INSTR_W(INSTR_W)) u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pgm_we_i   (pgm_we_i),
    .pgm_addr_i (pgm_addr_i),
    .pgm_data_i (pgm_data_i),
    .pc_o       (pc),
    .instr_o    (id_instr)
  );

  assign id_op  = decode_op(id_instr[OP_LSB +: OP_W]);
  assign id_rd  = id_instr[RD_LSB +: RA_W];
  assign id_rsa = id_instr[RSA_LSB +: RA_W];
  assign id_rsb = id_instr[RSB_LSB +: RA_W];
  assign id_imm = id_instr[IMM_LSB +: IMM_W];
  assign id_a   = (id_op == OP_MOVI) ? DATA_W'(id_imm) : rf_a;

  s5_regfile #(.DATA_W(DATA_W), .RA_W(RA_W)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wb_we),
    .wa_i     (wb_rd),
    .wd_i     (wb_data),
    .ra_a_i   (id_rsa),
    .ra_b_i   (id_rsb),
    .ra_dbg_i (dbg_addr_i),
    .rd_a_o   (rf_a),
    .rd_b_o   (rf_b),
    .rd_dbg_o (dbg_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_op <= OP_NOP;
      ex_rd <= '0;
      ex_a  <= '0;
      ex_b  <= '0;
    end else begin
      ex_op <= id_op;
      ex_rd <= id_rd;
      ex_a  <= id_a;
      ex_b  <= rf_b;
    end
  end

  s5_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (ex_op),
    .a_i   (ex_a),
    .b_i   (ex_b),
    .res_o (alu_res),
    .we_o  (alu_we)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we  <= 1'b0;
      mem_rd  <= '0;
      mem_res <= '0;
      wb_we   <= 1'b0;
      wb_rd   <= '0;
      wb_data <= '0;
    end else begin
      mem_we  <= alu_we;
      mem_rd  <= ex_rd;
      mem_res <= alu_res;
      wb_we   <= mem_we;
      wb_rd   <= mem_rd;
      wb_data <= mem_res;
    end
  end
endmodule

// File: rtl/stream5_core_chk.sv
module stream5_core_chk #(
  parameter int DATA_W = 8,
  parameter int PC_W   = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [PC_W-1:0]         pc_i,
  input s5_pkg::op_e             ex_op_i,
  input logic [DATA_W-1:0]       ex_a_i,
  input logic [DATA_W-1:0]       ex_b_i,
  input logic [DATA_W-1:0]       mem_res_i,
  input logic                    wb_we_i,
  input logic [DATA_W-1:0]       wb_data_i,
  input logic [s5_pkg::RA_W-1:0] wb_rd_i,
  input logic [s5_pkg::RA_W-1:0] dbg_addr_i,
  input logic [DATA_W-1:0]       dbg_data_i
);
  import s5_pkg::*;

  logic [2:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 3'd4) cyc_q <= cyc_q + 3'd1;
  end

  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> pc_i == PC_W'($past(pc_i) + 1)); // R9

  AST_RESET_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q < 3'd4) |-> !wb_we_i); // R2

  AST_WB_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_we_i && wb_rd_i == dbg_addr_i) |=>
      (!$stable(dbg_addr_i) || dbg_data_i == $past(wb_data_i))); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_we_i |=> (!$stable(dbg_addr_i) || $stable(dbg_data_i))); // R7

  AST_ADD_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_op_i == OP_ADD) |=> mem_res_i == DATA_W'($past(ex_a_i) + $past(ex_b_i))); // R5

  AST_MUL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_op_i == OP_MUL) |=> mem_res_i == DATA_W'($past(ex_a_i) * $past(ex_b_i))); // R6
endmodule

bind stream5_core stream5_core_chk #(.DATA_W(DATA_W), .PC_W(PC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pc_i       (pc),
  .ex_op_i    (ex_op),
  .ex_a_i     (ex_a),
  .ex_b_i     (ex_b),
  .mem_res_i  (mem_res),
  .wb_we_i    (wb_we),
  .wb_data_i  (wb_data),
  .wb_rd_i    (wb_rd),
  .dbg_addr_i (dbg_addr_i),
  .dbg_data_i (dbg_data_o)
);

// File: tb/sim_stream5_core.sv
module sim_stream5_core;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pgm_we = 1'b0;
  logic [3:0]  pgm_addr = '0;
  logic [11:0] pgm_data = '0;
  logic [1:0]  dbg_addr = '0;
  logic [7:0]  dbg_data;

  logic [11:0] prog [16];
  int ecnt;
  int n_run = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) ecnt <= 0; else ecnt <= ecnt + 1;

  stream5_core u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .pgm_we_i   (pgm_we),
    .pgm_addr_i (pgm_addr),
    .pgm_data_i (pgm_data),
    .dbg_addr_i (dbg_addr),
    .dbg_data_o (dbg_data)
  );

  function automatic logic [11:0] ins(int op, int rd, int ra, int rb);
    return {3'(op), 2'(rd), 2'(ra), 2'(rb), 3'b000};
  endfunction

  function automatic logic [11:0] movi(int rd, int imm);
    return {3'd1, 2'(rd), 3'b000, 4'(imm)};
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) prog[i] = '0;
  endtask

  // hold reset, write all slots, release on a falling edge
  task automatic load_and_start();
    @(negedge clk);
    rst_ni = 1'b0;
    for (int i = 0; i < 16; i++) begin
      pgm_we = 1'b1; pgm_addr = 4'(i); pgm_data = prog[i];
      @(posedge clk); @(negedge clk);
    end
    pgm_we = 1'b0;
    rst_ni = 1'b1;
  endtask

  task automatic wait_edges(int k);
    while (ecnt < k) @(negedge clk);
  endtask

  task automatic chk_reg(string req, int r, logic [7:0] exp);
    dbg_addr = 2'(r);
    #1;
    n_run++;
    if (dbg_data !== exp) begin
      n_fail++;
      $display("FAIL %s r%0d at edge %0d: actual %0d expected %0d", req, r, ecnt, dbg_data, exp);
    end
  endtask

  task automatic t_arith();
    clear_prog();
    prog[0]  = movi(0, 9);
    prog[1]  = movi(1, 15);
    prog[4]  = ins(2, 2, 0, 0);   // mov r2,r0
    prog[5]  = ins(3, 3, 0, 1);   // add r3,r0,r1
    prog[9]  = ins(4, 3, 3, 1);   // mul r3,r3,r1
    prog[10] = ins(4, 1, 1, 1);   // mul r1,r1,r1
    prog[14] = ins(3, 0, 3, 1);   // add r0,r3,r1
    load_and_start();
    wait_edges(4);  chk_reg("R2 bubbles", 0, 8'd0);
    wait_edges(5);  chk_reg("R2/R3 movi lands", 0, 8'd9);
    wait_edges(9);  chk_reg("R4 mov", 2, 8'd9);
    wait_edges(10); chk_reg("R5 add", 3, 8'd24);
    wait_edges(14); chk_reg("R6 mul wrap", 3, 8'd104);
    wait_edges(15); chk_reg("R6 mul square", 1, 8'd225);
    wait_edges(19); chk_reg("R5 add wrap", 0, 8'd73);
  endtask

  task automatic t_idle_ops();
    clear_prog();
    prog[0] = movi(0, 7);
    prog[1] = movi(1, 3);
    prog[4] = {3'd5, 2'd2, 7'h7f};
    prog[5] = {3'd6, 2'd3, 7'h2a};
    prog[6] = {3'd7, 2'd0, 7'h15};
    prog[7] = {3'd0, 2'd1, 7'h7f};
    prog[8] = {3'd5, 2'd1, 7'h01};
    load_and_start();
    wait_edges(14);
    chk_reg("R7 r0 kept", 0, 8'd7);
    chk_reg("R7 r1 kept", 1, 8'd3);
    chk_reg("R7 r2 kept", 2, 8'd0);
    chk_reg("R7 r3 kept", 3, 8'd0);
  endtask

  task automatic t_hazard();
    clear_prog();
    prog[0] = movi(0, 2);
    prog[4] = movi(0, 6);          // writes at edge 9
    prog[5] = ins(3, 3, 0, 0);     // adjacent: sees 2
    prog[7] = ins(2, 1, 0, 0);     // three after: stale 2
    prog[8] = ins(2, 2, 0, 0);     // four after: new 6
    load_and_start();
    wait_edges(14);
    chk_reg("R8 adjacent stale", 3, 8'd4);
    chk_reg("R8 gap3 stale", 1, 8'd2);
    chk_reg("R8 gap4 fresh", 2, 8'd6);
    chk_reg("R8 producer", 0, 8'd6);
  endtask

  task automatic t_wrap();
    clear_prog();
    prog[0] = ins(3, 1, 1, 2);     // add r1,r1,r2
    prog[1] = movi(2, 3);
    load_and_start();
    wait_edges(20); chk_reg("R9 first pass", 1, 8'd0);
    wait_edges(21); chk_reg("R9 second pass", 1, 8'd3);
    wait_edges(36); chk_reg("R9 before third", 1, 8'd3);
    wait_edges(37); chk_reg("R9 third pass", 1, 8'd6);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    chk_reg("R1 reset r0", 0, 8'd0);
    chk_reg("R1 reset r1", 1, 8'd0);
    chk_reg("R1 reset r2", 2, 8'd0);
    chk_reg("R1 reset r3", 3, 8'd0);
    clear_prog();
    prog[0] = movi(3, 11);
    load_and_start();
    wait_edges(4); chk_reg("R1 restart not yet", 3, 8'd0);
    wait_edges(5); chk_reg("R1 restart slot0", 3, 8'd11);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1-R9 run: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    t_arith();
    t_idle_ops();
    t_hazard();
    t_wrap();
    t_reset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule